// File: doc/BRIEF.md
# Reservation-Table Pipeline Initiation Controller

This controller guards the entry of a nonlinear pipeline, one in which a task may pass through the same stage more than once on its way through. Stage usage over time is fixed by a reservation table. The table is a parameter matrix with one row per stage and one column per cycle after entry. A mark at row s, column c means that a task entered at cycle t occupies stage s in cycle t+c.

A requester raises `req_i` whenever a task is waiting to enter. In the same cycle the controller answers with `grant_o`. A grant is given only when the new task cannot need any stage in any cycle already claimed by a task in flight. From the table the block derives the set of forbidden latencies, which are the distances between two marks in the same row. A refused request changes no state, and the requester keeps it raised until it is granted. The block also reports `busy_o`, a map of which stage is claimed in which coming cycle by the tasks already admitted.

The table is stored flat as bit `s*TBL_LEN + c`. The parameter `GRANT_MODE` selects how the grant decision is made. One variant keeps a shifting collision-state register built from the forbidden-latency vector. The other compares the table directly against the busy map. Both variants must give the same grants.

Top module: `rtp_init_ctrl`

## Requirements
- R1: After reset no task is in flight: `busy_o` is all zero, and a request in the first cycle after reset is granted in that same cycle.
- R2: `grant_o` is combinational on `req_i` in the current cycle, and is never high while `req_i` is low.
- R3: Take a single task in flight, granted j cycles earlier with 1 <= j < TBL_LEN. If j equals the column difference of two marks in one row of the table, a request now is refused. With the default table (stage 0 at columns 0 and 5, stage 1 at 1 and 4, stage 2 at 2 and 3), the forbidden latencies are 1, 3 and 5.
- R4: Take a single task in flight. A request at a latency that no row forbids is granted, and this includes every latency of TBL_LEN or more (with the default table: 2, 4, 6, 7 and above).
- R5: With several tasks in flight, a request is granted only if the latency to every one of them is permitted.
- R6: A refused request leaves the state unchanged. A request held high after a grant is next granted at the smallest permitted latency (2 with the default table).
- R7: Bit `s*TBL_LEN + c` of `busy_o` is 1 exactly when some task granted a cycles ago (1 <= a < TBL_LEN) has a mark at row s, column a+c. Tasks granted in the current cycle are not included.
- R8: Whenever `grant_o` is high, the table ANDed with `busy_o` is zero, so no stage is ever claimed twice in one cycle.
- R9: The collision-state variant and the direct-overlap variant of `GRANT_MODE` give identical `grant_o` and `busy_o` for the same request sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | A task is waiting to enter the pipeline |
| grant_o | output | 1 | The waiting task enters in this cycle |
| busy_o | output | NUM_STAGES*TBL_LEN | Per stage, per coming cycle claim map of tasks already admitted |

## Verification
The bench sweeps every request pattern over ten consecutive cycles and lets each pattern drain, so it reaches latencies of 1 through TBL_LEN+3 and stacks of two and three tasks in flight. A design that derived a forbidden latency wrongly, for example by counting distances across rows or by dropping the largest difference, would grant at latency 1, 3 or 5, or refuse at 2 or 4. A state register that shifted by the wrong amount, or was updated on a refused request, would delay the held request past latency 2 or let it through too early. The busy map is compared bit by bit on every cycle, which catches an off-by-one age and a table column read from the wrong end. Both grant variants run side by side on the same stimulus.

// File: rtl/rtp_pkg.sv
package rtp_pkg;

   // Default configuration: 3 stages, 6 cycles per pass.
   // Row 0 marks columns 0,5; row 1 marks 1,4; row 2 marks 2,3.
   localparam int unsigned RTP_DEF_STAGES = 3;
   localparam int unsigned RTP_DEF_LEN    = 6;
   localparam logic [17:0] RTP_DEF_TABLE  = 18'h0C4A1;

   typedef enum logic {
      GRANT_BY_STATE   = 1'b0,
      GRANT_BY_OVERLAP = 1'b1
   } grant_mode_e;

endpackage

// File: rtl/rtp_cvec_gen.sv
// Derives the forbidden-latency vector from the reservation table.
// cvec_o[j-1] is set when latency j (1..L-1) would collide.
module rtp_cvec_gen #(
   parameter int unsigned S = 3,
   parameter int unsigned L = 6,
   parameter logic [S*L-1:0] TABLE = '0
) (
   output logic [L-2:0] cvec_o
);

   always_comb begin
      cvec_o = '0;
      for (int j = 1; j < L; j++) begin
         for (int s = 0; s < S; s++) begin
            for (int c = 0; c < L; c++) begin
               if (c + j < L) begin
                  if (TABLE[s*L + c] && TABLE[s*L + c + j]) begin
                     cvec_o[j-1] = 1'b1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/rtp_coll_state.sv
// Shifting collision state: bit k means an initiation k cycles from now
// is forbidden. Advances by one each cycle, merges the vector on a grant.
module rtp_coll_state #(
   parameter int unsigned L = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   input  logic [L-2:0] cvec_i,
   output logic         blocked_o
);

   logic [L-2:0] st_q;
   logic [L-2:0] st_d;

   always_comb begin
      st_d = {1'b0, st_q[L-2:1]};
      if (adv_i) begin
         st_d = st_d | cvec_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q <= st_d;
      end
   end

   assign blocked_o = st_q[0];

endmodule

// File: rtl/rtp_age_hist.sv
// Age history of admitted tasks: age_o[a-1] set when a grant happened a cycles ago.
module rtp_age_hist #(
   parameter int unsigned L = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   output logic [L-2:0] age_o
);

   logic [L-2:0] age_q;

   generate
      if (L == 2) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) age_q <= '0;
            else        age_q <= push_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) age_q <= '0;
            else        age_q <= {age_q[L-3:0], push_i};
         end
      end
   endgenerate

   assign age_o = age_q;

endmodule

// File: rtl/rtp_busy_map.sv
// Stage-by-cycle claim map: table rows shifted by every in-flight task's age.
module rtp_busy_map #(
   parameter int unsigned S = 3,
   parameter int unsigned L = 6,
   parameter logic [S*L-1:0] TABLE = '0
) (
   input  logic [L-2:0]   age_i,
   output logic [S*L-1:0] busy_o
);

   generate
      for (genvar s = 0; s < S; s++) begin : g_stage
         for (genvar c = 0; c < L; c++) begin : g_col
            logic hit;
            always_comb begin
               hit = 1'b0;
               for (int a = 1; a < L; a++) begin
                  if (a + c < L) begin
                     hit = hit | (age_i[a-1] & TABLE[s*L + a + c]);
                  end
               end
            end
            assign busy_o[s*L + c] = hit;
         end
      end
   endgenerate

endmodule

// File: rtl/rtp_init_ctrl.sv
module rtp_init_ctrl #(
   parameter int unsigned NUM_STAGES = rtp_pkg::RTP_DEF_STAGES,
   parameter int unsigned TBL_LEN    = rtp_pkg::RTP_DEF_LEN,
   parameter logic [NUM_STAGES*TBL_LEN-1:0] TABLE = rtp_pkg::RTP_DEF_TABLE,
   parameter rtp_pkg::grant_mode_e GRANT_MODE = rtp_pkg::GRANT_BY_STATE
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_i,
   output logic                          grant_o,
   output logic [NUM_STAGES*TBL_LEN-1:0] busy_o
);

   localparam int unsigned MAP_W = NUM_STAGES * TBL_LEN;

   function automatic logic first_col_marked();
      logic any = 1'b0;
      for (int s = 0; s < NUM_STAGES; s++) begin
         any = any | TABLE[s*TBL_LEN];
      end
      return any;
   endfunction

   // Elaboration-time parameter checks
   generate
      if (TBL_LEN < 3) begin : g_bad_len
         $error("rtp_init_ctrl: TBL_LEN must be at least 3");
      end
      if (NUM_STAGES < 1) begin : g_bad_stages
         $error("rtp_init_ctrl: NUM_STAGES must be at least 1");
      end
      if (!first_col_marked()) begin : g_bad_entry
         $error("rtp_init_ctrl: table column 0 must hold a mark");
      end
   endgenerate

   logic [TBL_LEN-2:0] age;
   logic               blocked;

   rtp_age_hist #(.L(TBL_LEN)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (grant_o),
      .age_o  (age)
   );

   rtp_busy_map #(.S(NUM_STAGES), .L(TBL_LEN), .TABLE(TABLE)) u_map (
      .age_i  (age),
      .busy_o (busy_o)
   );

   generate
      if (GRANT_MODE == rtp_pkg::GRANT_BY_STATE) begin : g_state
         logic [TBL_LEN-2:0] cvec;

         rtp_cvec_gen #(.S(NUM_STAGES), .L(TBL_LEN), .TABLE(TABLE)) u_cvec (
            .cvec_o (cvec)
         );

         rtp_coll_state #(.L(TBL_LEN)) u_state (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv_i     (grant_o),
            .cvec_i    (cvec),
            .blocked_o (blocked)
         );
      end else begin : g_overlap
         logic [MAP_W-1:0] clash;
         assign clash   = busy_o & TABLE;
         assign blocked = |clash;
      end
   endgenerate

   assign grant_o = req_i & ~blocked;

endmodule

// File: rtl/rtp_init_ctrl_chk.sv
module rtp_init_ctrl_chk #(
   parameter int unsigned S = 3,
   parameter int unsigned L = 6,
   parameter logic [S*L-1:0] TABLE = '0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_i,
   input logic         grant_o,
   input logic [S*L-1:0] busy_o
);

   function automatic logic [L-2:0] calc_forb();
      logic [L-2:0] f = '0;
      for (int s = 0; s < S; s++) begin
         for (int x = 0; x < L; x++) begin
            for (int y = x + 1; y < L; y++) begin
               if (TABLE[s*L + x] && TABLE[s*L + y]) f[y-x-1] = 1'b1;
            end
         end
      end
      return f;
   endfunction

   localparam logic [L-2:0] FORB = calc_forb();

   logic             live_q;
   logic             prev_grant_q;
   logic [S*L-1:0]   prev_busy_q;
   logic [L-2:0]     ghist_q;
   logic [S*L-1:0]   shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q       <= 1'b0;
         prev_grant_q <= 1'b0;
         prev_busy_q  <= '0;
         ghist_q      <= '0;
      end else begin
         live_q       <= 1'b1;
         prev_grant_q <= grant_o;
         prev_busy_q  <= busy_o;
         ghist_q      <= {ghist_q[L-3:0], grant_o};
      end
   end

   always_comb begin
      shifted = '0;
      for (int k = 0; k < S*L; k++) begin
         if ((k % L) < L - 1) begin
            shifted[k] = prev_busy_q[k+1] | (prev_grant_q & TABLE[k+1]);
         end
      end
   end

   // R1: first cycle after reset is idle and grants a request at once
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !live_q |-> (busy_o == '0) && (grant_o == req_i));

   // R2: no grant without a request
   a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> req_i);

   // R5: no grant at a forbidden distance from any earlier grant
   a_r5_no_forbidden_gap: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> ((ghist_q & FORB) == '0));

   // R7: busy map advances by one column and adds the table on a grant
   a_r7_busy_advance: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (busy_o == shifted));

   // R8: a granted task never meets a claimed stage-cycle
   a_r8_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> ((busy_o & TABLE) == '0));

endmodule

bind rtp_init_ctrl rtp_init_ctrl_chk #(
   .S(NUM_STAGES), .L(TBL_LEN), .TABLE(TABLE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_i   (req_i),
   .grant_o (grant_o),
   .busy_o  (busy_o)
);

// File: tb/rtp_init_ctrl_tb.sv
module rtp_init_ctrl_tb_top;

   localparam int S = 3;
   localparam int L = 6;
   localparam logic [S*L-1:0] TBL = 18'h0C4A1;
   localparam int SWEEP_LEN = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic grant_a, grant_b;
   logic [S*L-1:0] busy_a, busy_b;

   int n_checks = 0;
   int n_fails  = 0;

   logic [15:0] bh = '0;      // bit a: model grant a cycles ago
   logic [15:0] forb = '0;    // bit j: latency j forbidden (model)

   always #10 clk = ~clk;     // 50 MHz

   rtp_init_ctrl #(.NUM_STAGES(S), .TBL_LEN(L), .TABLE(TBL),
                   .GRANT_MODE(rtp_pkg::GRANT_BY_STATE)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .grant_o(grant_a), .busy_o(busy_a));

   rtp_init_ctrl #(.NUM_STAGES(S), .TBL_LEN(L), .TABLE(TBL),
                   .GRANT_MODE(rtp_pkg::GRANT_BY_OVERLAP)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .grant_o(grant_b), .busy_o(busy_b));

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic model_grant(input logic r);
      logic g = r;
      for (int a = 1; a < L; a++) begin
         if (bh[a] && forb[a]) g = 1'b0;
      end
      return g;
   endfunction

   function automatic logic [S*L-1:0] model_busy();
      logic [S*L-1:0] m = '0;
      for (int s = 0; s < S; s++)
         for (int c = 0; c < L; c++)
            for (int a = 1; a < L; a++)
               if (a + c < L && bh[a] && TBL[s*L + a + c]) m[s*L + c] = 1'b1;
      return m;
   endfunction

   // One cycle: drive, sample mid-low-phase, compare, advance model.
   task automatic step(input logic r, input string gtag, output logic g_out);
      logic eg;
      logic [S*L-1:0] eb;
      @(negedge clk);
      req = r;
      #5;
      eg = model_grant(r);
      eb = model_busy();
      check(grant_a == eg, gtag, {31'd0, grant_a}, {31'd0, eg});
      check(busy_a == eb, "R7 busy map", {14'd0, busy_a}, {14'd0, eb});
      check(grant_b == grant_a, "R9 variant grant", {31'd0, grant_b}, {31'd0, grant_a});
      check(busy_b == busy_a, "R9 variant busy", {14'd0, busy_b}, {14'd0, busy_a});
      if (!r) check(grant_a == 1'b0, "R2 no req no grant", {31'd0, grant_a}, 32'd0);
      g_out = eg;
      bh = ((bh << 1) | {14'd0, eg, 1'b0}) & 16'((1 << L) - 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req = 1'b0;
      bh = '0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      logic g;
      int first_lat;
      // Forbidden latencies: differences of marks within one row
      for (int s = 0; s < S; s++)
         for (int x = 0; x < L; x++)
            for (int y = 0; y < x; y++)
               if (TBL[s*L + x] && TBL[s*L + y]) forb[x - y] = 1'b1;

      // R1: reset state and immediate first grant
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #5;
      check(busy_a == '0, "R1 busy after reset", {14'd0, busy_a}, 32'd0);
      check(busy_b == '0, "R1 busy after reset (variant)", {14'd0, busy_b}, 32'd0);
      step(1'b1, "R1 first request granted", g);
      check(g == 1'b1, "R1 model first grant", {31'd0, g}, 32'd1);

      // R3/R4: single task in flight, probe each latency 1..L+2
      for (int j = 1; j <= L + 2; j++) begin
         do_reset();
         step(1'b1, "R1 grant after reset", g);
         for (int k = 1; k < j; k++) step(1'b0, "R2 idle", g);
         step(1'b1, (j < L && forb[j]) ? "R3 forbidden latency refused"
                                       : "R4 permitted latency granted", g);
      end

      // R6: held request after a grant enters at the smallest permitted latency
      do_reset();
      step(1'b1, "R6 initial grant", g);
      first_lat = 0;
      for (int k = 1; k <= L; k++) begin
         step(1'b1, "R6 held request", g);
         if (g && first_lat == 0) first_lat = k;
      end
      check(first_lat == 2, "R6 first regrant latency", 32'(first_lat), 32'd2);

      // R5/R7/R9: every request pattern over SWEEP_LEN cycles, then drain
      for (int p = 0; p < (1 << SWEEP_LEN); p++) begin
         do_reset();
         for (int i = 0; i < SWEEP_LEN; i++) step(p[i], "R5 multi-task grant", g);
         for (int i = 0; i < L; i++) step(1'b0, "R7 drain", g);
         check(busy_a == '0, "R7 drained map empty", {14'd0, busy_a}, 32'd0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule